// File: doc/BRIEF.md
# Packet Round Robin Output Arbiter

This block is the output stage of a single router link. Every incoming direction writes its flits into a FIFO of its own. An arbiter then merges those FIFOs onto one outgoing flit stream, at most one flit per cycle. Only FIFOs that hold data compete for the link. The choice between them rotates round-robin, and a grant covers one whole packet. Once a packet's first flit has been sent, the rest of that packet follows before any other direction is looked at.

Upstream nodes are never stalled, because the block offers no ready signal. A flit that arrives at a full FIFO is discarded, and a sticky per-direction overflow flag records the loss. Each output flit also reports which direction it came from. Traffic from different directions can therefore only affect each other at this arbiter.

Top module: `pkt_rr_out_arb`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, every bit of `ovf` is 0, and the round-robin pointer designates direction 0.
- R2: Flit kinds use this 2-bit code: 2'b00 body, 2'b01 header, 2'b10 last, 2'b11 single-flit packet (header and last at once). A packet ends with kind 2'b10 or 2'b11. The kind and data of each flit reach the output unchanged.
- R3: After a header of a packet from direction d has been output, every following output flit comes from d until a flit that ends the packet has been output. If d's FIFO runs dry in the middle of a packet, the output idles and no other direction is served.
- R4: Between packets, the grant goes to the first non-empty FIFO found at or after the pointer, searching in increasing direction index and wrapping around. Empty FIFOs are skipped.
- R5: When the last flit of a packet from direction d is sent, the pointer moves to d+1 modulo the number of directions.
- R6: At most one flit is output per cycle, and `out_src` gives the index of the direction the flit came from.
- R7: Flits from one direction leave in the order in which they were written.
- R8: A write to a full FIFO is dropped and sets that direction's `ovf` bit. The bit stays set until reset. Other directions and the flits already stored are not affected.
- R9: `out_valid` stays 0 while all FIFOs are empty and no packet is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | N_DIR | Per-direction flit write strobe |
| in_kind | input | 2*N_DIR | Per-direction flit kind, direction d at bits [2d+1:2d] |
| in_data | input | FLIT_DW*N_DIR | Per-direction flit payload, direction d at slice d |
| out_valid | output | 1 | Output flit present this cycle |
| out_kind | output | 2 | Kind of output flit |
| out_data | output | FLIT_DW | Payload of output flit |
| out_src | output | SRC_W | Direction index of output flit |
| ovf | output | N_DIR | Sticky per-direction overflow flags |

## Verification
The bench stalls one packet in the middle by withholding its last flit. A design that re-arbitrates at flit level would then let another direction's flits cut into the stalled packet. It also sends a packet from one direction alone and then offers traffic on all directions. Starting the next round from the wrong place shows up as a rotated output order, and a pointer that fails to wrap shows up when the served direction is the highest one. The overflow case fills one FIFO to capacity while its packet is blocked. A FIFO that overwrote old entries, or a flag that cleared itself, would corrupt the drained packet or lose the sticky bit.

// File: rtl/pkt_arb_pkg.sv
package pkt_arb_pkg;

    parameter int FLIT_DW = 32;

    typedef enum logic [1:0] {
        FK_BODY = 2'b00,
        FK_HEAD = 2'b01,
        FK_TAIL = 2'b10,
        FK_SOLO = 2'b11
    } flit_kind_e;

    typedef struct packed {
        flit_kind_e           kind;
        logic [FLIT_DW-1:0]   data;
    } flit_t;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_SEND = 1'b1
    } arb_state_e;

    // a flit closes its packet when the "last" bit of the kind is set
    function automatic logic kind_ends(input flit_kind_e k);
        return k[1];
    endfunction

endpackage

// File: rtl/pkt_flit_fifo.sv
module pkt_flit_fifo
    import pkt_arb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  flit_t wr_flit,
    input  logic  rd_en,
    output flit_t rd_flit,
    output logic  empty,
    output logic  ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    flit_t          mem [DEPTH];
    logic [AW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  cnt;
    logic           full, accept, take;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign accept  = wr_en && !full;
    assign take    = rd_en && !empty;
    assign rd_flit = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= wr_flit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            ovf    <= 1'b0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
            if (wr_en && full) ovf <= 1'b1;
        end
    end

    // R7
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> !empty);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> ovf);
    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

endmodule

// File: rtl/pkt_rr_pick.sv
module pkt_rr_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= N) j = j - N;
            if (!any && req[j]) begin
                any      = 1'b1;
                idx      = IW'(j);
                grant[j] = 1'b1;
            end
        end
    end

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R4
    grant_to_req_chk: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0);
    // R4
    grant_when_req_chk: assert property (@(posedge clk) disable iff (rst)
        (|req) |-> (|grant));

endmodule

// File: rtl/pkt_rr_out_arb.sv
module pkt_rr_out_arb
    import pkt_arb_pkg::*;
#(
    parameter int N_DIR      = 4,
    parameter int FIFO_DEPTH = 16,
    parameter int SRC_W      = (N_DIR > 1) ? $clog2(N_DIR) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_DIR-1:0]           in_valid,
    input  logic [2*N_DIR-1:0]         in_kind,
    input  logic [FLIT_DW*N_DIR-1:0]   in_data,
    output logic                       out_valid,
    output logic [1:0]                 out_kind,
    output logic [FLIT_DW-1:0]         out_data,
    output logic [SRC_W-1:0]           out_src,
    output logic [N_DIR-1:0]           ovf
);
    flit_t              head_flit [N_DIR];
    logic [N_DIR-1:0]   empty_vec, pop_vec, grant_vec;
    logic [SRC_W-1:0]   pick_idx, sel, cur_q, ptr_q, out_src_q;
    logic               pick_any, pop, ends;
    flit_t              sel_flit, out_flit_q;
    logic               out_valid_q;
    arb_state_e         state_q;

    function automatic logic [SRC_W-1:0] next_dir(input logic [SRC_W-1:0] d);
        return (d == SRC_W'(N_DIR - 1)) ? '0 : d + 1'b1;
    endfunction

    for (genvar d = 0; d < N_DIR; d++) begin : g_dir
        flit_t wf;
        assign wf.kind = flit_kind_e'(in_kind[2*d +: 2]);
        assign wf.data = in_data[FLIT_DW*d +: FLIT_DW];

        pkt_flit_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (in_valid[d]),
            .wr_flit (wf),
            .rd_en   (pop_vec[d]),
            .rd_flit (head_flit[d]),
            .empty   (empty_vec[d]),
            .ovf     (ovf[d])
        );
    end

    pkt_rr_pick #(.N(N_DIR), .IW(SRC_W)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (~empty_vec),
        .ptr   (ptr_q),
        .grant (grant_vec),
        .idx   (pick_idx),
        .any   (pick_any)
    );

    always_comb begin
        if (state_q == ARB_SEND) begin
            sel     = cur_q;
            pop     = !empty_vec[cur_q];
            pop_vec = pop ? (N_DIR'(1) << cur_q) : '0;
        end else begin
            sel     = pick_idx;
            pop     = pick_any;
            pop_vec = grant_vec;
        end
        sel_flit = head_flit[sel];
        ends     = kind_ends(sel_flit.kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ARB_IDLE;
            cur_q       <= '0;
            ptr_q       <= '0;
            out_valid_q <= 1'b0;
            out_flit_q  <= '0;
            out_src_q   <= '0;
        end else begin
            out_valid_q <= pop;
            if (pop) begin
                out_flit_q <= sel_flit;
                out_src_q  <= sel;
                if (ends) begin
                    state_q <= ARB_IDLE;
                    ptr_q   <= next_dir(sel);
                end else begin
                    state_q <= ARB_SEND;
                    cur_q   <= sel;
                end
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_kind  = out_flit_q.kind;
    assign out_data  = out_flit_q.data;
    assign out_src   = out_src_q;

    // packet tracking seen from the output port only
    logic             open_q;
    logic [SRC_W-1:0] open_src_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q     <= 1'b0;
            open_src_q <= '0;
        end else if (out_valid_q) begin
            open_q     <= !out_flit_q.kind[1];
            open_src_q <= out_src_q;
        end
    end

    // R3
    pkt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_q && open_q) |-> (out_src_q == open_src_q));
    // R5
    ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid_q && out_flit_q.kind[1]) |-> (ptr_q == next_dir(out_src_q)));
    // R6
    src_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid_q |-> (int'(out_src_q) < N_DIR));
    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_IDLE && (&empty_vec)) |=> !out_valid_q);

endmodule

// File: tb/pkt_rr_out_arb_tb.sv
`timescale 1ns/1ps
module pkt_rr_out_arb_tb;
    import pkt_arb_pkg::*;

    localparam int N = 4;
    localparam int D = 16;
    localparam int SW = 2;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [N-1:0]          in_valid = '0;
    logic [2*N-1:0]        in_kind = '0;
    logic [FLIT_DW*N-1:0]  in_data = '0;
    logic                  out_valid;
    logic [1:0]            out_kind;
    logic [FLIT_DW-1:0]    out_data;
    logic [SW-1:0]         out_src;
    logic [N-1:0]          ovf;

    always #2.5 clk = ~clk;

    pkt_rr_out_arb #(.N_DIR(N), .FIFO_DEPTH(D)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_data(in_data), .out_valid(out_valid), .out_kind(out_kind),
        .out_data(out_data), .out_src(out_src), .ovf(ovf)
    );

    typedef struct { int src; logic [1:0] kind; logic [31:0] data; } exp_t;
    typedef struct { bit v; logic [1:0] kind; logic [31:0] data; } stim_t;

    exp_t  exp_q [$];
    stim_t sq [N][$];
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string cur_req = "R1";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, cur_req, "unexpected flit src", out_src, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(int'(out_src) == e.src, cur_req, "src (R6)", out_src, e.src);
                check(out_kind == e.kind, cur_req, "kind (R2)", out_kind, e.kind);
                check(out_data == e.data, cur_req, "data (R7)", out_data, e.data);
            end
        end
    end

    task automatic add_flit(input int d, input logic [1:0] k, input logic [31:0] dat,
                            input bit expect_it);
        stim_t s;
        exp_t  e;
        s.v = 1'b1; s.kind = k; s.data = dat;
        sq[d].push_back(s);
        if (expect_it) begin
            e.src = d; e.kind = k; e.data = dat;
            exp_q.push_back(e);
        end
    endtask

    function automatic logic [31:0] mkd(input int d, input int tag, input int i);
        return {8'(d), 8'(tag), 16'(i)};
    endfunction

    task automatic add_pkt(input int d, input int len, input int tag);
        for (int i = 0; i < len; i++) begin
            logic [1:0] k;
            if (len == 1)          k = 2'b11;
            else if (i == 0)       k = 2'b01;
            else if (i == len - 1) k = 2'b10;
            else                   k = 2'b00;
            add_flit(d, k, mkd(d, tag, i), 1'b1);
        end
    endtask

    task automatic add_gap(input int d, input int n);
        for (int i = 0; i < n; i++) begin
            stim_t s;
            s.v = 1'b0; s.kind = 2'b00; s.data = '0;
            sq[d].push_back(s);
        end
    endtask

    task automatic run_stim();
        bit busy;
        busy = 1'b1;
        while (busy) begin
            @(negedge clk);
            busy = 1'b0;
            for (int d = 0; d < N; d++) begin
                if (sq[d].size() > 0) begin
                    stim_t s;
                    s = sq[d].pop_front();
                    in_valid[d] = s.v;
                    in_kind[2*d +: 2] = s.kind;
                    in_data[FLIT_DW*d +: FLIT_DW] = s.data;
                    busy = 1'b1;
                end else begin
                    in_valid[d] = 1'b0;
                end
            end
        end
        in_valid = '0;
    endtask

    task automatic drain(input string req);
        int n;
        n = 0;
        while (exp_q.size() > 0 && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, req, "missing flits", exp_q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        do_reset();
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(ovf == '0, "R1", "ovf after reset", ovf, 0);

        // R9 idle with empty FIFOs
        cur_req = "R9";
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R9", "idle out_valid", out_valid, 0);
        end

        // R4 R6 R7 two full rounds, varying lengths; pointer starts at 0 (R1)
        cur_req = "R4";
        for (int r = 0; r < 2; r++)
            for (int d = 0; d < N; d++)
                add_pkt(d, (d == 3) ? 1 : d + 2, r);
        run_stim();
        drain("R4");

        // R4 empty FIFOs skipped: dirs 1 and 3 only
        cur_req = "R4";
        do_reset();
        add_pkt(1, 3, 5);
        add_pkt(3, 3, 5);
        run_stim();
        drain("R4");

        // R5 wrap: pointer now at 0 after serving 3
        cur_req = "R5";
        add_pkt(0, 2, 6);
        add_pkt(3, 2, 6);
        run_stim();
        drain("R5");

        // R5 pointer after serving dir 2 alone, then all four compete
        cur_req = "R5";
        do_reset();
        add_pkt(2, 2, 7);
        run_stim();
        drain("R5");
        add_pkt(3, 2, 8);
        add_pkt(0, 2, 8);
        add_pkt(1, 2, 8);
        add_pkt(2, 2, 8);
        run_stim();
        drain("R5");

        // R3 packet held while its FIFO runs dry mid-packet
        cur_req = "R3";
        do_reset();
        add_flit(0, 2'b01, mkd(0, 9, 0), 1'b1);
        add_gap(0, 4);
        add_flit(0, 2'b00, mkd(0, 9, 1), 1'b1);
        add_gap(0, 2);
        add_flit(0, 2'b10, mkd(0, 9, 2), 1'b1);
        add_pkt(1, 3, 9);
        run_stim();
        drain("R3");

        // R8 overflow: dir 0 packet stalls, dir 1 overfills
        cur_req = "R8";
        do_reset();
        add_flit(0, 2'b01, mkd(0, 10, 0), 1'b1);
        run_stim();
        repeat (3) @(negedge clk);
        begin
            exp_t e;
            e.src = 0; e.kind = 2'b10; e.data = mkd(0, 10, 1);
            exp_q.push_back(e);
        end
        add_pkt(1, D, 10);
        add_flit(1, 2'b00, mkd(1, 10, 100), 1'b0);
        add_flit(1, 2'b00, mkd(1, 10, 101), 1'b0);
        run_stim();
        repeat (2) @(negedge clk);
        check(ovf == 4'b0010, "R8", "ovf after overfill", ovf, 4'b0010);
        check(out_valid == 1'b0, "R3", "stalled packet blocks others", out_valid, 0);
        add_flit(0, 2'b10, mkd(0, 10, 1), 1'b0);
        run_stim();
        drain("R8");
        check(ovf == 4'b0010, "R8", "ovf sticky after drain", ovf, 4'b0010);
        do_reset();
        check(ovf == '0, "R8", "ovf cleared by reset", ovf, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule